// File: doc/BRIEF.md
# Branch and Next-Pointer Unit

This block holds the 16-bit instruction pointer of a byte-coded processor and works out where execution goes after every control-transfer instruction. A decoder presents one decoded transfer at a time on `issue_i`, along with:

- the transfer kind and a condition code;
- the 16-bit immediate, whose low byte is the relative displacement;
- the two address registers P and Q;
- the word just read back from the stack;
- the zero and carry flags.

The unit then spends the instruction's full cycle count before it commits the new pointer. Transfers run in three groups:

- Jumps: absolute, register-indirect through P or Q, and relative by a signed 8-bit offset. The relative form may be gated by one of six conditions built from the flags.
- Calls: a link call hands the return address to the Q register file port. A stack call asks the stack logic to store the return address minus one as a 16-bit word.
- Return: resumes at the popped word plus one.

The instruction at pointer `ip` is taken to start at `ip`. The length is 3 bytes for forms that carry a 16-bit immediate, 2 bytes for relative forms and 1 byte for register and return forms. The return address is the byte that follows the call. A relative displacement is added to the address of the byte that follows the branch.

While a multi-cycle transfer is in flight `busy_o` is high and `issue_i` is ignored. Link writes, push requests and pop acknowledges are one-cycle pulses, issued together with the pointer update. The surrounding stack logic moves its stack pointer by two on each push and each pop.

Top module: `branch_npc_unit`

## Requirements
- R1: After reset `ip_o` equals the parameter `RESET_IP`, `busy_o` is low, and `link_we_o`, `push_req_o` and `pop_take_o` are low.
- R2: `kind_i` encodes the transfer as follows: 0 absolute jump, 1 register jump, 2 relative jump, 3 link call to immediate, 4 link call through register, 5 stack call to immediate, 6 stack call through register, 7 return. The kinds occupy 3, 1, 2, 3, 1, 5, 3 and 3 cycles in that order. `ip_o` changes at the last of those clock edges, counted from the accepting edge, and `busy_o` stays high for the cycles in between.
- R3: An absolute jump loads `ip_o` with `imm_i`.
- R4: A register jump loads `ip_o` with `p_i` when `reg_sel_i` is 0 and with `q_i` when it is 1. Register calls use the same selection.
- R5: A relative jump gives `ip + 2 + sext(imm_i[7:0])` when taken and `ip + 2` when not taken, modulo 2^16.
- R6: `cond_i` selects when a relative jump is taken. The codes are:
  - 0: always
  - 1: zero clear
  - 2: zero set
  - 3: carry clear
  - 4: carry set
  - 5: zero clear and carry set
  - 6: zero set or carry clear
  - 7: never

  A not-taken branch still takes 2 cycles.
- R7: A link call sets `ip_o` to its target. For one cycle it also raises `link_we_o`, with `link_data_o` equal to the old `ip` plus the instruction length (3 for the immediate form, 1 for the register form).
- R8: A stack call sets `ip_o` to its target. For one cycle it also raises `push_req_o`, with `push_data_o` equal to the return address minus one.
- R9: A return sets `ip_o` to `pop_word_i + 1`, taking `pop_word_i` at the final edge, and raises `pop_take_o` for that one cycle.
- R10: `issue_i` has no effect while `busy_o` is high. Inputs that change during a transfer do not alter its result, except `pop_word_i` for a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Present a decoded transfer |
| kind_i | input | 3 | Transfer kind |
| cond_i | input | 3 | Condition code for relative jumps |
| reg_sel_i | input | 1 | Register source: 0 P, 1 Q |
| imm_i | input | 16 | Immediate; low byte is the displacement |
| p_i | input | 16 | P register value |
| q_i | input | 16 | Q register value |
| pop_word_i | input | 16 | Word popped from the stack |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| ip_o | output | 16 | Instruction pointer |
| busy_o | output | 1 | Multi-cycle transfer in flight |
| link_we_o | output | 1 | Write return address to Q |
| link_data_o | output | 16 | Return address for Q |
| push_req_o | output | 1 | Push a 16-bit word |
| push_data_o | output | 16 | Word to push |
| pop_take_o | output | 1 | Popped word consumed |

## Verification
The bench builds the unit with its default 16-bit pointer and 8-bit displacement, and with `RESET_IP` set to 0x0100. The sweep covers every condition code against all four flag states, with both a forward and a backward displacement. It places branches near the top of the address space so that pointer wrap is reached. Call and return round trips go through both the link and the stack convention. The cycle count of every kind is measured from `busy_o`.

// File: rtl/npc_pkg.sv
package npc_pkg;
    parameter int IP_W   = 16;
    parameter int DISP_W = 8;
    localparam int CNT_W = 3;

    typedef enum logic [2:0] {
        K_JABS   = 3'd0,
        K_JREG   = 3'd1,
        K_JREL   = 3'd2,
        K_LC_IMM = 3'd3,
        K_LC_REG = 3'd4,
        K_SC_IMM = 3'd5,
        K_SC_REG = 3'd6,
        K_RET    = 3'd7
    } jkind_e;

    typedef struct packed {
        logic [IP_W-1:0]  ip;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        jkind_e           kind;
        logic [IP_W-1:0]  tgt;
        logic [IP_W-1:0]  ret;
        logic             link_we;
        logic             push_req;
        logic             pop_take;
    } npc_state_t;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval (
    input  logic [2:0] cond_i,
    input  logic       z_i,
    input  logic       c_i,
    output logic       take_o
);
    always_comb begin
        unique case (cond_i)
            3'd0:    take_o = 1'b1;
            3'd1:    take_o = !z_i;
            3'd2:    take_o = z_i;
            3'd3:    take_o = !c_i;
            3'd4:    take_o = c_i;
            3'd5:    take_o = !z_i && c_i;
            3'd6:    take_o = z_i || !c_i;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
    import npc_pkg::*;
(
    input  jkind_e           kind_i,
    input  logic [IP_W-1:0]  ip_i,
    input  logic [IP_W-1:0]  imm_i,
    input  logic [IP_W-1:0]  p_i,
    input  logic [IP_W-1:0]  q_i,
    input  logic             reg_sel_i,
    input  logic             take_i,
    output logic [IP_W-1:0]  tgt_o,
    output logic [IP_W-1:0]  ret_o,
    output logic [CNT_W-1:0] cycles_o
);
    localparam int EXT_W = IP_W - DISP_W;

    logic [IP_W-1:0] disp_ext;
    logic [IP_W-1:0] reg_src;
    logic [IP_W-1:0] len;

    assign disp_ext = {{EXT_W{imm_i[DISP_W-1]}}, imm_i[DISP_W-1:0]};
    assign reg_src  = reg_sel_i ? q_i : p_i;

    always_comb begin
        tgt_o    = imm_i;
        len      = IP_W'(1);
        cycles_o = CNT_W'(1);
        unique case (kind_i)
            K_JABS:   begin tgt_o = imm_i;   len = IP_W'(3); cycles_o = CNT_W'(3); end
            K_JREG:   begin tgt_o = reg_src; len = IP_W'(1); cycles_o = CNT_W'(1); end
            K_JREL:   begin
                len      = IP_W'(2);
                cycles_o = CNT_W'(2);
                tgt_o    = take_i ? (ip_i + IP_W'(2) + disp_ext) : (ip_i + IP_W'(2));
            end
            K_LC_IMM: begin tgt_o = imm_i;   len = IP_W'(3); cycles_o = CNT_W'(3); end
            K_LC_REG: begin tgt_o = reg_src; len = IP_W'(1); cycles_o = CNT_W'(1); end
            K_SC_IMM: begin tgt_o = imm_i;   len = IP_W'(3); cycles_o = CNT_W'(5); end
            K_SC_REG: begin tgt_o = reg_src; len = IP_W'(1); cycles_o = CNT_W'(3); end
            default:  begin tgt_o = imm_i;   len = IP_W'(1); cycles_o = CNT_W'(3); end
        endcase
        ret_o = ip_i + len;
    end
endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit
    import npc_pkg::*;
#(
    parameter logic [15:0] RESET_IP = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_i,
    input  logic [2:0]  kind_i,
    input  logic [2:0]  cond_i,
    input  logic        reg_sel_i,
    input  logic [15:0] imm_i,
    input  logic [15:0] p_i,
    input  logic [15:0] q_i,
    input  logic [15:0] pop_word_i,
    input  logic        flag_z_i,
    input  logic        flag_c_i,
    output logic [15:0] ip_o,
    output logic        busy_o,
    output logic        link_we_o,
    output logic [15:0] link_data_o,
    output logic        push_req_o,
    output logic [15:0] push_data_o,
    output logic        pop_take_o
);
    npc_state_t st_d, st_q;

    jkind_e           kind_w;
    logic             take_w;
    logic [IP_W-1:0]  tgt_w;
    logic [IP_W-1:0]  ret_w;
    logic [CNT_W-1:0] cyc_w;

    assign kind_w = jkind_e'(kind_i);

    npc_cond_eval u_cond (
        .cond_i (cond_i),
        .z_i    (flag_z_i),
        .c_i    (flag_c_i),
        .take_o (take_w)
    );

    npc_target_calc u_tgt (
        .kind_i    (kind_w),
        .ip_i      (st_q.ip),
        .imm_i     (imm_i),
        .p_i       (p_i),
        .q_i       (q_i),
        .reg_sel_i (reg_sel_i),
        .take_i    (take_w),
        .tgt_o     (tgt_w),
        .ret_o     (ret_w),
        .cycles_o  (cyc_w)
    );

    logic            apply;
    jkind_e          a_kind;
    logic [IP_W-1:0] a_tgt;

    always_comb begin
        st_d          = st_q;
        st_d.link_we  = 1'b0;
        st_d.push_req = 1'b0;
        st_d.pop_take = 1'b0;
        apply         = 1'b0;
        a_kind        = st_q.kind;
        a_tgt         = st_q.tgt;

        if (!st_q.busy && issue_i) begin
            st_d.kind = kind_w;
            st_d.tgt  = tgt_w;
            st_d.ret  = ret_w;
            if (cyc_w == CNT_W'(1)) begin
                apply  = 1'b1;
                a_kind = kind_w;
                a_tgt  = tgt_w;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = cyc_w - CNT_W'(1);
            end
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                apply     = 1'b1;
            end
        end

        if (apply) begin
            unique case (a_kind)
                K_RET: begin
                    st_d.ip       = pop_word_i + IP_W'(1);
                    st_d.pop_take = 1'b1;
                end
                K_LC_IMM, K_LC_REG: begin
                    st_d.ip      = a_tgt;
                    st_d.link_we = 1'b1;
                end
                K_SC_IMM, K_SC_REG: begin
                    st_d.ip       = a_tgt;
                    st_d.push_req = 1'b1;
                end
                default: st_d.ip = a_tgt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ip   <= RESET_IP;
            st_q.kind <= K_JABS;
        end else begin
            st_q <= st_d;
        end
    end

    assign ip_o        = st_q.ip;
    assign busy_o      = st_q.busy;
    assign link_we_o   = st_q.link_we;
    assign link_data_o = st_q.ret;
    assign push_req_o  = st_q.push_req;
    assign push_data_o = st_q.ret - IP_W'(1);
    assign pop_take_o  = st_q.pop_take;
endmodule

// File: rtl/branch_npc_checker.sv
module branch_npc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_i,
    input logic [15:0] pop_word_i,
    input logic [15:0] ip_o,
    input logic        busy_o,
    input logic        link_we_o,
    input logic        push_req_o,
    input logic        pop_take_o
);
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_we_o, push_req_o, pop_take_o}));

    assert_push_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_req_o |=> !push_req_o);

    assert_ret_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_take_o |-> (ip_o == $past(pop_word_i) + 16'd1));

    assert_ip_moves_on_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ip_o) |-> ($past(busy_o) || $past(issue_i)));

    assert_link_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (($past(issue_i) && !$past(busy_o)) || ($past(busy_o) && !busy_o)));
endmodule

bind branch_npc_unit branch_npc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .pop_word_i (pop_word_i),
    .ip_o       (ip_o),
    .busy_o     (busy_o),
    .link_we_o  (link_we_o),
    .push_req_o (push_req_o),
    .pop_take_o (pop_take_o)
);

// File: tb/branch_npc_unit_bench.sv
module branch_npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [2:0]  cond_i = '0;
    logic        reg_sel_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [15:0] p_i = '0;
    logic [15:0] q_i = '0;
    logic [15:0] pop_word_i = '0;
    logic        flag_z_i = 1'b0;
    logic        flag_c_i = 1'b0;
    logic [15:0] ip_o, link_data_o, push_data_o;
    logic        busy_o, link_we_o, push_req_o, pop_take_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_npc_unit #(.RESET_IP(16'h0100)) u_branch_npc_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int cyc_of(input int k);
        case (k)
            0: return 3; 1: return 1; 2: return 2; 3: return 3;
            4: return 1; 5: return 5; 6: return 3; default: return 3;
        endcase
    endfunction

    task automatic run_op(input int k, input logic [2:0] cnd, input logic sel,
                          input logic [15:0] imm, input bit z, input bit c);
        int n;
        @(negedge clk);
        kind_i = 3'(k); cond_i = cnd; reg_sel_i = sel; imm_i = imm;
        flag_z_i = z; flag_c_i = c; issue_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0;
        n = 1;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
        // R2: cycles measured from busy
        chk(n == cyc_of(k), "R2", 32'(n), 32'(cyc_of(k)));
    endtask

    initial begin
        logic [15:0] base, exp_ip, ret;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ip_o == 16'h0100 && !busy_o, "R1", {ip_o, 15'd0, busy_o}, 32'h01000000);
        chk(!link_we_o && !push_req_o && !pop_take_o, "R1",
            {29'd0, link_we_o, push_req_o, pop_take_o}, 0);
        rst_n = 1'b1;

        // R3 absolute jump
        run_op(0, 0, 0, 16'h1234, 0, 0);
        chk(ip_o == 16'h1234, "R3", ip_o, 16'h1234);

        // R4 register jumps
        p_i = 16'hA0A0; q_i = 16'h5B5B;
        run_op(1, 0, 0, 16'h0, 0, 0);
        chk(ip_o == 16'hA0A0, "R4", ip_o, 16'hA0A0);
        run_op(1, 0, 1, 16'h0, 0, 0);
        chk(ip_o == 16'h5B5B, "R4", ip_o, 16'h5B5B);

        // R5 / R6 sweep of all conditions against all flag states
        for (int cd = 0; cd < 8; cd++) begin
            for (int f = 0; f < 4; f++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    bit z, c, tk;
                    logic [7:0] d;
                    z = f[1]; c = f[0];
                    d = dir ? 8'hE0 : 8'h10;
                    base = 16'h4000 + 16'(cd * 64 + f * 8);
                    case (cd)
                        0: tk = 1; 1: tk = !z; 2: tk = z; 3: tk = !c;
                        4: tk = c; 5: tk = !z && c; 6: tk = z || !c; default: tk = 0;
                    endcase
                    run_op(0, 0, 0, base, 0, 0);
                    run_op(2, 3'(cd), 0, {8'h00, d}, z, c);
                    exp_ip = base + 16'd2 + (tk ? {{8{d[7]}}, d} : 16'd0);
                    chk(ip_o == exp_ip, "R6", ip_o, exp_ip);
                end
            end
        end

        // R5 wrap near top of address space
        run_op(0, 0, 0, 16'hFFFE, 0, 0);
        run_op(2, 0, 0, 16'h0005, 0, 0);
        chk(ip_o == 16'h0005, "R5", ip_o, 16'h0005);

        // R7 link call, immediate then register
        run_op(0, 0, 0, 16'h3000, 0, 0);
        run_op(3, 0, 0, 16'h7700, 0, 0);
        chk(link_we_o && link_data_o == 16'h3003, "R7", link_data_o, 16'h3003);
        chk(ip_o == 16'h7700, "R7", ip_o, 16'h7700);
        @(negedge clk);
        chk(!link_we_o, "R7", link_we_o, 0);
        p_i = 16'h6100;
        run_op(4, 0, 0, 16'h0, 0, 0);
        chk(link_we_o && link_data_o == 16'h7701 && ip_o == 16'h6100, "R7", link_data_o, 16'h7701);

        // R8 / R9 stack call and return round trip, immediate form
        run_op(0, 0, 0, 16'h2222, 0, 0);
        run_op(5, 0, 0, 16'h8800, 0, 0);
        ret = push_data_o;
        chk(push_req_o && push_data_o == 16'h2224, "R8", push_data_o, 16'h2224);
        chk(ip_o == 16'h8800, "R8", ip_o, 16'h8800);
        @(negedge clk);
        chk(!push_req_o, "R8", push_req_o, 0);
        pop_word_i = ret;
        run_op(7, 0, 0, 16'h0, 0, 0);
        chk(pop_take_o && ip_o == 16'h2225, "R9", ip_o, 16'h2225);

        // register form round trip through Q
        q_i = 16'h9990;
        run_op(6, 0, 1, 16'h0, 0, 0);
        chk(push_req_o && push_data_o == 16'h2225 && ip_o == 16'h9990, "R8", push_data_o, 16'h2225);
        pop_word_i = 16'h2225;
        run_op(7, 0, 0, 16'h0, 0, 0);
        chk(ip_o == 16'h2226, "R9", ip_o, 16'h2226);

        // R10 issue held while busy with changing inputs
        @(negedge clk);
        kind_i = 3'd0; imm_i = 16'h1111; issue_i = 1'b1;
        @(posedge clk); @(negedge clk);
        imm_i = 16'h5555; kind_i = 3'd1; p_i = 16'hDEAD;
        @(posedge clk); @(negedge clk);
        chk(ip_o == 16'h2226 && busy_o, "R10", ip_o, 16'h2226);
        @(posedge clk); @(negedge clk);
        chk(ip_o == 16'h1111, "R10", ip_o, 16'h1111);
        issue_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule